// File: doc/BRIEF.md
# Dual-Port Inter-Processor Mailbox

This block links two processor subsystems that share one clock. Each subsystem sees its own AXI4-Lite slave port with an identical register layout. Two first-in first-out queues sit between the ports. Words written by side 0 are read by side 1, and words written by side 1 are read by side 0. Ordering is preserved in both directions, and the two directions operate independently.

Each side can see its own queue state. The status word reports whether the receive queue is empty and whether the send queue is full. It also reports two programmable level comparisons: one tells the sender that there is room, and one tells the receiver that data has built up. Software misuse is recorded in sticky error bits that clear when read. A write into a full queue is dropped, and a read from an empty queue returns zero.

Top module: `mbox_dual_axil`

## Requirements
- R1: A write is accepted in the cycle where both write-address valid and write-data valid are high and no write response is pending. BVALID rises one cycle later and stays high until BREADY. ARREADY is high whenever no read response is pending, and RVALID rises one cycle after acceptance. While RREADY is low, RVALID and RDATA hold steady. Every response code is 0 (OKAY).
- R2: A word written at offset 0x00 of one side is returned, in write order, by reads of offset 0x08 on the other side. Each such read removes exactly one word.
- R3: When the send queue already holds DEPTH words, a write to 0x00 is discarded and bit 1 of the error word at 0x14 is set.
- R4: A read of 0x08 while the receive queue is empty returns 0, removes nothing, and sets bit 0 of the error word.
- R5: The status word at 0x10 carries the following bits: bit 0 is receive-empty, bit 1 is send-full, bit 2 is send-level-active, and bit 3 is receive-level-active. Bits above these read as 0.
- R6: Send-level-active is 1 when the send queue fill is at most the send threshold at 0x18. Receive-level-active is 1 when the receive queue fill exceeds the receive threshold at 0x1C. Each threshold stores only the low log2(DEPTH) bits of the written word and reads them back right-justified.
- R7: Error bits are sticky. A read of 0x14 returns their current value and then clears them. An error event in the same cycle as that read remains set afterwards.
- R8: Writes to 0x08, 0x10, 0x14 and reserved offsets change nothing. Reads of 0x00, of reserved offsets (0x04, 0x0C, 0x20 to 0x3C) and of unaligned addresses return 0.
- R9: A synchronous active-low reset empties both queues and clears the thresholds and error bits. Status then reads 0x5 on both sides.
- R10: A push on one side and a pop of the same queue on the other side can happen in the same cycle. The word in flight is not lost, and the queue order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s0_awaddr | input | ADDR_W | Side 0 write address |
| s0_awvalid | input | 1 | Side 0 write address valid |
| s0_awready | output | 1 | Side 0 write address ready |
| s0_wdata | input | DATA_W | Side 0 write data |
| s0_wvalid | input | 1 | Side 0 write data valid |
| s0_wready | output | 1 | Side 0 write data ready |
| s0_bresp | output | 2 | Side 0 write response code |
| s0_bvalid | output | 1 | Side 0 write response valid |
| s0_bready | input | 1 | Side 0 write response ready |
| s0_araddr | input | ADDR_W | Side 0 read address |
| s0_arvalid | input | 1 | Side 0 read address valid |
| s0_arready | output | 1 | Side 0 read address ready |
| s0_rdata | output | DATA_W | Side 0 read data |
| s0_rresp | output | 2 | Side 0 read response code |
| s0_rvalid | output | 1 | Side 0 read data valid |
| s0_rready | input | 1 | Side 0 read data ready |
| s1_awaddr | input | ADDR_W | Side 1 write address |
| s1_awvalid | input | 1 | Side 1 write address valid |
| s1_awready | output | 1 | Side 1 write address ready |
| s1_wdata | input | DATA_W | Side 1 write data |
| s1_wvalid | input | 1 | Side 1 write data valid |
| s1_wready | output | 1 | Side 1 write data ready |
| s1_bresp | output | 2 | Side 1 write response code |
| s1_bvalid | output | 1 | Side 1 write response valid |
| s1_bready | input | 1 | Side 1 write response ready |
| s1_araddr | input | ADDR_W | Side 1 read address |
| s1_arvalid | input | 1 | Side 1 read address valid |
| s1_arready | output | 1 | Side 1 read address ready |
| s1_rdata | output | DATA_W | Side 1 read data |
| s1_rresp | output | 2 | Side 1 read response code |
| s1_rvalid | output | 1 | Side 1 read data valid |
| s1_rready | input | 1 | Side 1 read data ready |

## Verification
A write takes effect on the clock edge that accepts it. Queue fill, error bits and thresholds are therefore already updated for any read accepted on a later edge. Read data is captured on the edge that accepts the read and appears with RVALID one cycle later. Every bench task waits for the accepting edge before it samples, then samples the response 1 ns after the following edge, so each value is compared in the cycle it is due. The two timing races are started with fork at the same falling edge so that both accesses land on one rising edge: a push racing a pop, and an error read racing a new error.

// File: rtl/mbox_pkg.sv
// Shared constants for the dual-port mailbox: register offsets (byte
// addresses within one side's window) and bit positions inside the status
// and error words. Assumes a 64-byte window per side.
package mbox_pkg;

    localparam logic [5:0] OFS_TXDATA = 6'h00;
    localparam logic [5:0] OFS_RXDATA = 6'h08;
    localparam logic [5:0] OFS_STATUS = 6'h10;
    localparam logic [5:0] OFS_ERROR  = 6'h14;
    localparam logic [5:0] OFS_SENDTH = 6'h18;
    localparam logic [5:0] OFS_RECVTH = 6'h1C;

    localparam int ST_RX_EMPTY = 0;
    localparam int ST_TX_FULL  = 1;
    localparam int ST_SEND_LVL = 2;
    localparam int ST_RECV_LVL = 3;

    localparam int ER_EMPTY = 0;
    localparam int ER_FULL  = 1;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/mbox_fifo.sv
// Single-clock queue carrying words from one side to the other.
// Assumes DEPTH is a power of two, so the pointers wrap naturally, and
// assumes the caller never pushes when full or pops when empty.
// The head word is presented combinationally.
module mbox_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  level_o,
    output logic              full_o,
    output logic              empty_o
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  count_q;

    // Store the pushed word at the write pointer.
    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr_q] <= push_data_i;
    end

    // Advance pointers and the fill count; reset empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_i) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
            if (pop_i)  rd_ptr_q <= rd_ptr_q + PTR_W'(1);
            if (push_i && !pop_i)      count_q <= count_q + CNT_W'(1);
            else if (pop_i && !push_i) count_q <= count_q - CNT_W'(1);
        end
    end

    assign head_o  = mem[rd_ptr_q];
    assign level_o = count_q;
    assign full_o  = (count_q == CNT_W'(DEPTH));
    assign empty_o = (count_q == '0);

    // R3: the side logic must never push into a full queue.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    // R4: the side logic must never pop an empty queue.
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
    // R2: a lone push grows the fill by exactly one.
    p_level_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (level_o == $past(level_o) + CNT_W'(1)));
    // R10: a simultaneous push and pop keep the fill unchanged.
    p_level_same_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> $stable(level_o));

endmodule

// File: rtl/mbox_side.sv
// One side of the mailbox: AXI4-Lite slave handshakes, register decode,
// threshold registers, sticky error bits and the push/pop requests to the
// two queues. Assumes single outstanding transactions per channel pair.
// Every response is OKAY; byte strobes are not used (full-word writes).
module mbox_side
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 6,
    localparam int TH_W  = $clog2(DEPTH),
    localparam int CNT_W = TH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr_i,
    input  logic              awvalid_i,
    output logic              awready_o,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wvalid_i,
    output logic              wready_o,
    output logic [1:0]        bresp_o,
    output logic              bvalid_o,
    input  logic              bready_i,
    input  logic [ADDR_W-1:0] araddr_i,
    input  logic              arvalid_i,
    output logic              arready_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [1:0]        rresp_o,
    output logic              rvalid_o,
    input  logic              rready_i,
    output logic              tx_push_o,
    output logic [DATA_W-1:0] tx_data_o,
    input  logic              tx_full_i,
    input  logic [CNT_W-1:0]  tx_level_i,
    output logic              rx_pop_o,
    input  logic [DATA_W-1:0] rx_head_i,
    input  logic              rx_empty_i,
    input  logic [CNT_W-1:0]  rx_level_i
);

    logic              bvalid_q, rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic [TH_W-1:0]   send_th_q, recv_th_q;
    logic [1:0]        err_q;
    logic              wr_fire, rd_fire;
    logic              full_evt, empty_evt, err_clr;
    logic              send_lvl, recv_lvl;
    logic [DATA_W-1:0] rd_word;

    // Handshake acceptance: one write and one read may be taken per cycle.
    assign wr_fire   = awvalid_i && wvalid_i && !bvalid_q;
    assign rd_fire   = arvalid_i && !rvalid_q;
    assign awready_o = wr_fire;
    assign wready_o  = wr_fire;
    assign arready_o = !rvalid_q;
    assign bvalid_o  = bvalid_q;
    assign rvalid_o  = rvalid_q;
    assign rdata_o   = rdata_q;
    assign bresp_o   = RESP_OKAY;
    assign rresp_o   = RESP_OKAY;

    // Queue requests and error events derived from the decoded access.
    assign tx_data_o = wdata_i;
    assign tx_push_o = wr_fire && (awaddr_i == ADDR_W'(OFS_TXDATA)) && !tx_full_i;
    assign full_evt  = wr_fire && (awaddr_i == ADDR_W'(OFS_TXDATA)) && tx_full_i;
    assign rx_pop_o  = rd_fire && (araddr_i == ADDR_W'(OFS_RXDATA)) && !rx_empty_i;
    assign empty_evt = rd_fire && (araddr_i == ADDR_W'(OFS_RXDATA)) && rx_empty_i;
    assign err_clr   = rd_fire && (araddr_i == ADDR_W'(OFS_ERROR));

    // Level comparators against the programmed thresholds.
    assign send_lvl = (tx_level_i <= {1'b0, send_th_q});
    assign recv_lvl = (rx_level_i >  {1'b0, recv_th_q});

    // Read multiplexer: selects the word returned for the accepted address.
    always_comb begin
        rd_word = '0;
        if (araddr_i == ADDR_W'(OFS_RXDATA)) begin
            rd_word = rx_empty_i ? '0 : rx_head_i;
        end else if (araddr_i == ADDR_W'(OFS_STATUS)) begin
            rd_word[ST_RX_EMPTY] = rx_empty_i;
            rd_word[ST_TX_FULL]  = tx_full_i;
            rd_word[ST_SEND_LVL] = send_lvl;
            rd_word[ST_RECV_LVL] = recv_lvl;
        end else if (araddr_i == ADDR_W'(OFS_ERROR)) begin
            rd_word[1:0] = err_q;
        end else if (araddr_i == ADDR_W'(OFS_SENDTH)) begin
            rd_word[TH_W-1:0] = send_th_q;
        end else if (araddr_i == ADDR_W'(OFS_RECVTH)) begin
            rd_word[TH_W-1:0] = recv_th_q;
        end
    end

    // Write response channel: raise after acceptance, drop on BREADY.
    always_ff @(posedge clk) begin
        if (!rst_n)        bvalid_q <= 1'b0;
        else if (wr_fire)  bvalid_q <= 1'b1;
        else if (bready_i) bvalid_q <= 1'b0;
    end

    // Read data channel: capture the word at acceptance, hold until RREADY.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (rd_fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_word;
        end else if (rready_i) begin
            rvalid_q <= 1'b0;
        end
    end

    // Threshold registers keep only the low log2(DEPTH) bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_th_q <= '0;
            recv_th_q <= '0;
        end else if (wr_fire) begin
            if (awaddr_i == ADDR_W'(OFS_SENDTH)) send_th_q <= wdata_i[TH_W-1:0];
            if (awaddr_i == ADDR_W'(OFS_RECVTH)) recv_th_q <= wdata_i[TH_W-1:0];
        end
    end

    // Sticky error bits: clear on read, a same-cycle event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q[ER_FULL]  <= (err_q[ER_FULL]  && !err_clr) || full_evt;
            err_q[ER_EMPTY] <= (err_q[ER_EMPTY] && !err_clr) || empty_evt;
        end
    end

    // R1: a pending write response is held until taken.
    p_bvalid_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid_q && !bready_i) |=> bvalid_q);
    // R1: a pending read response holds its data until taken.
    p_rvalid_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_q && !rready_i) |=> (rvalid_q && $stable(rdata_q)));
    // R7: a full error survives anything except an error-word read.
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q[ER_FULL] && !err_clr) |=> err_q[ER_FULL]);
    // R3: a rejected write always leaves the full error set.
    p_full_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full_evt |=> err_q[ER_FULL]);
    // R4: a read of an empty queue always leaves the empty error set.
    p_empty_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        empty_evt |=> err_q[ER_EMPTY]);

endmodule

// File: rtl/mbox_dual_axil.sv
// Top of the dual-port mailbox. Queue k carries words from side k to the
// opposite side. Both sides run on the shared clock and reset.
module mbox_dual_axil #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s0_awaddr,
    input  logic              s0_awvalid,
    output logic              s0_awready,
    input  logic [DATA_W-1:0] s0_wdata,
    input  logic              s0_wvalid,
    output logic              s0_wready,
    output logic [1:0]        s0_bresp,
    output logic              s0_bvalid,
    input  logic              s0_bready,
    input  logic [ADDR_W-1:0] s0_araddr,
    input  logic              s0_arvalid,
    output logic              s0_arready,
    output logic [DATA_W-1:0] s0_rdata,
    output logic [1:0]        s0_rresp,
    output logic              s0_rvalid,
    input  logic              s0_rready,
    input  logic [ADDR_W-1:0] s1_awaddr,
    input  logic              s1_awvalid,
    output logic              s1_awready,
    input  logic [DATA_W-1:0] s1_wdata,
    input  logic              s1_wvalid,
    output logic              s1_wready,
    output logic [1:0]        s1_bresp,
    output logic              s1_bvalid,
    input  logic              s1_bready,
    input  logic [ADDR_W-1:0] s1_araddr,
    input  logic              s1_arvalid,
    output logic              s1_arready,
    output logic [DATA_W-1:0] s1_rdata,
    output logic [1:0]        s1_rresp,
    output logic              s1_rvalid,
    input  logic              s1_rready
);

    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic              q_push  [2];
    logic [DATA_W-1:0] q_wdata [2];
    logic              q_pop   [2];
    logic [DATA_W-1:0] q_head  [2];
    logic [CNT_W-1:0]  q_level [2];
    logic              q_full  [2];
    logic              q_empty [2];

    // One queue per direction.
    for (genvar k = 0; k < 2; k++) begin : g_queue
        mbox_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_i     (q_push[k]),
            .push_data_i(q_wdata[k]),
            .pop_i      (q_pop[k]),
            .head_o     (q_head[k]),
            .level_o    (q_level[k]),
            .full_o     (q_full[k]),
            .empty_o    (q_empty[k])
        );
    end

    mbox_side #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) side0_i (
        .clk(clk), .rst_n(rst_n),
        .awaddr_i(s0_awaddr), .awvalid_i(s0_awvalid), .awready_o(s0_awready),
        .wdata_i(s0_wdata), .wvalid_i(s0_wvalid), .wready_o(s0_wready),
        .bresp_o(s0_bresp), .bvalid_o(s0_bvalid), .bready_i(s0_bready),
        .araddr_i(s0_araddr), .arvalid_i(s0_arvalid), .arready_o(s0_arready),
        .rdata_o(s0_rdata), .rresp_o(s0_rresp), .rvalid_o(s0_rvalid),
        .rready_i(s0_rready),
        .tx_push_o(q_push[0]), .tx_data_o(q_wdata[0]), .tx_full_i(q_full[0]),
        .tx_level_i(q_level[0]),
        .rx_pop_o(q_pop[1]), .rx_head_i(q_head[1]), .rx_empty_i(q_empty[1]),
        .rx_level_i(q_level[1])
    );

    mbox_side #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) side1_i (
        .clk(clk), .rst_n(rst_n),
        .awaddr_i(s1_awaddr), .awvalid_i(s1_awvalid), .awready_o(s1_awready),
        .wdata_i(s1_wdata), .wvalid_i(s1_wvalid), .wready_o(s1_wready),
        .bresp_o(s1_bresp), .bvalid_o(s1_bvalid), .bready_i(s1_bready),
        .araddr_i(s1_araddr), .arvalid_i(s1_arvalid), .arready_o(s1_arready),
        .rdata_o(s1_rdata), .rresp_o(s1_rresp), .rvalid_o(s1_rvalid),
        .rready_i(s1_rready),
        .tx_push_o(q_push[1]), .tx_data_o(q_wdata[1]), .tx_full_i(q_full[1]),
        .tx_level_i(q_level[1]),
        .rx_pop_o(q_pop[0]), .rx_head_i(q_head[0]), .rx_empty_i(q_empty[0]),
        .rx_level_i(q_level[0])
    );

endmodule

// File: tb/mbox_dual_axil_tb.sv
// Self-checking bench for mbox_dual_axil with DEPTH 16. Expected values are
// computed from the requirements; results are sampled 1 ns after edges.
module mbox_dual_axil_tb_top;

    localparam int DW = 32;
    localparam int DEPTH = 16;
    localparam int AW = 6;
    localparam logic [5:0] A_TX = 6'h00, A_RX = 6'h08, A_ST = 6'h10,
                           A_ER = 6'h14, A_STH = 6'h18, A_RTH = 6'h1C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [AW-1:0] s0_awaddr = '0, s1_awaddr = '0, s0_araddr = '0, s1_araddr = '0;
    logic [DW-1:0] s0_wdata = '0, s1_wdata = '0;
    logic s0_awvalid = 0, s0_wvalid = 0, s0_bready = 1, s0_arvalid = 0, s0_rready = 1;
    logic s1_awvalid = 0, s1_wvalid = 0, s1_bready = 1, s1_arvalid = 0, s1_rready = 1;
    logic s0_awready, s0_wready, s0_bvalid, s0_arready, s0_rvalid;
    logic s1_awready, s1_wready, s1_bvalid, s1_arready, s1_rvalid;
    logic [1:0] s0_bresp, s0_rresp, s1_bresp, s1_rresp;
    logic [DW-1:0] s0_rdata, s1_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    mbox_dual_axil #(.DATA_W(DW), .DEPTH(DEPTH), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .s0_awaddr(s0_awaddr), .s0_awvalid(s0_awvalid), .s0_awready(s0_awready),
        .s0_wdata(s0_wdata), .s0_wvalid(s0_wvalid), .s0_wready(s0_wready),
        .s0_bresp(s0_bresp), .s0_bvalid(s0_bvalid), .s0_bready(s0_bready),
        .s0_araddr(s0_araddr), .s0_arvalid(s0_arvalid), .s0_arready(s0_arready),
        .s0_rdata(s0_rdata), .s0_rresp(s0_rresp), .s0_rvalid(s0_rvalid),
        .s0_rready(s0_rready),
        .s1_awaddr(s1_awaddr), .s1_awvalid(s1_awvalid), .s1_awready(s1_awready),
        .s1_wdata(s1_wdata), .s1_wvalid(s1_wvalid), .s1_wready(s1_wready),
        .s1_bresp(s1_bresp), .s1_bvalid(s1_bvalid), .s1_bready(s1_bready),
        .s1_araddr(s1_araddr), .s1_arvalid(s1_arvalid), .s1_arready(s1_arready),
        .s1_rdata(s1_rdata), .s1_rresp(s1_rresp), .s1_rvalid(s1_rvalid),
        .s1_rready(s1_rready)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int k);
        return 32'hC0DE_0000 + 32'(k) * 32'h0001_0203;
    endfunction

    // Full-word write on one side; returns after the response is consumed.
    task automatic wr(input int s, input logic [5:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        if (s == 0) begin s0_awaddr = a; s0_wdata = d; s0_awvalid = 1; s0_wvalid = 1; end
        else        begin s1_awaddr = a; s1_wdata = d; s1_awvalid = 1; s1_wvalid = 1; end
        #1;
        while (!((s == 0) ? s0_awready : s1_awready)) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        if (s == 0) begin s0_awvalid = 0; s0_wvalid = 0; end
        else        begin s1_awvalid = 0; s1_wvalid = 0; end
        @(posedge clk); #1;
    endtask

    // Read on one side; returns the data and response code.
    task automatic rd(input int s, input logic [5:0] a, output logic [DW-1:0] d,
                      output logic [1:0] r);
        @(negedge clk);
        if (s == 0) begin s0_araddr = a; s0_arvalid = 1; end
        else        begin s1_araddr = a; s1_arvalid = 1; end
        #1;
        while (!((s == 0) ? s0_arready : s1_arready)) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        if (s == 0) begin s0_arvalid = 0; d = s0_rdata; r = s0_rresp; end
        else        begin s1_arvalid = 0; d = s1_rdata; r = s1_rresp; end
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin : main
        logic [DW-1:0] v;
        logic [1:0] rr;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R9: reset state on both sides
        rd(0, A_ST, v, rr);  chk("R9 status0 after reset", v, 32'h5);
        rd(1, A_ST, v, rr);  chk("R9 status1 after reset", v, 32'h5);
        rd(0, A_ER, v, rr);  chk("R9 error0 after reset", v, 0);
        rd(1, A_STH, v, rr); chk("R9 send threshold1 after reset", v, 0);
        chk("R1 read response OKAY", 32'(rr), 0);

        // R1: write response held while BREADY low
        s0_bready = 0;
        @(negedge clk); s0_awaddr = A_RTH; s0_wdata = 3; s0_awvalid = 1; s0_wvalid = 1;
        #1; chk("R1 awready on both valids", 32'(s0_awready), 1);
        @(posedge clk); #1; s0_awvalid = 0; s0_wvalid = 0;
        chk("R1 bvalid one cycle after accept", 32'(s0_bvalid), 1);
        chk("R1 bresp OKAY", 32'(s0_bresp), 0);
        @(posedge clk); #1; chk("R1 bvalid held", 32'(s0_bvalid), 1);
        s0_bready = 1;
        @(posedge clk); #1; chk("R1 bvalid dropped after bready", 32'(s0_bvalid), 0);

        // R1: read data held while RREADY low
        s0_rready = 0;
        @(negedge clk); s0_araddr = A_RTH; s0_arvalid = 1;
        @(posedge clk); #1; s0_arvalid = 0;
        chk("R1 rvalid after accept", 32'(s0_rvalid), 1);
        chk("R6 receive threshold readback", s0_rdata, 3);
        #1; chk("R1 arready low while response pending", 32'(s0_arready), 0);
        @(posedge clk); #1; chk("R1 rvalid held", 32'(s0_rvalid), 1);
        chk("R1 rdata stable", s0_rdata, 3);
        s0_rready = 1;
        @(posedge clk); #1; chk("R1 rvalid dropped", 32'(s0_rvalid), 0);
        wr(0, A_RTH, 0);

        // R6: only the low bits of a threshold are kept
        wr(0, A_STH, 32'hFFFF_FFF7);
        rd(0, A_STH, v, rr); chk("R6 threshold truncation", v, 7);
        wr(0, A_STH, 0);

        // R8: writes to read-only and reserved offsets change nothing
        wr(0, A_RX, 32'h1234);
        wr(0, A_ST, 32'hFFFF);
        wr(0, A_ER, 32'h3);
        wr(0, 6'h04, 32'hAAAA);
        wr(0, 6'h24, 32'h7);
        rd(1, A_ST, v, rr); chk("R8 side1 still empty after ignored writes", v, 32'h5);
        rd(0, A_ST, v, rr); chk("R8 side0 status unchanged", v, 32'h5);
        rd(0, A_ER, v, rr); chk("R8 error0 unchanged", v, 0);
        for (int k = 0; k < 16; k++) begin
            logic [5:0] a;
            a = 6'(k * 4);
            if (a == A_RX || a == A_ST || a == A_ER || a == A_STH || a == A_RTH) continue;
            rd(0, a, v, rr); chk("R8 reserved or write-only reads zero", v, 0);
        end
        rd(0, 6'h19, v, rr); chk("R8 unaligned reads zero", v, 0);

        // R5 R6: sweep every fill level against every threshold value
        for (int lvl = 0; lvl <= DEPTH; lvl++) begin
            for (int t = 0; t < DEPTH; t++) begin
                wr(0, A_STH, 32'(t));
                rd(0, A_ST, v, rr);
                chk("R6 send-level bit2", 32'(v[2]), 32'(lvl <= t));
                chk("R5 full bit1", 32'(v[1]), 32'(lvl == DEPTH));
                wr(1, A_RTH, 32'(t));
                rd(1, A_ST, v, rr);
                chk("R6 receive-level bit3", 32'(v[3]), 32'(lvl > t));
                chk("R5 empty bit0", 32'(v[0]), 32'(lvl == 0));
                chk("R5 upper status bits zero", v >> 4, 0);
            end
            if (lvl < DEPTH) wr(0, A_TX, pat(lvl));
        end

        // R3: write into a full queue is dropped and flagged
        wr(0, A_TX, 32'hDEAD_BEEF);
        rd(0, A_ER, v, rr); chk("R3 full error set", v, 32'h2);
        rd(0, A_ER, v, rr); chk("R7 cleared after read", v, 0);

        // R2: drain in order on the other side
        for (int k = 0; k < DEPTH; k++) begin
            rd(1, A_RX, v, rr); chk("R2 order and data side0 to side1", v, pat(k));
        end
        // R4: empty read returns zero and flags
        rd(1, A_RX, v, rr); chk("R4 empty read returns zero", v, 0);
        rd(1, A_ER, v, rr); chk("R4 empty error set", v, 32'h1);
        rd(1, A_ER, v, rr); chk("R7 empty error cleared", v, 0);
        rd(1, A_ST, v, rr); chk("R4 nothing popped, still empty", 32'(v[0]), 1);

        // R2: reverse direction
        for (int k = 0; k < 3; k++) wr(1, A_TX, ~pat(k));
        for (int k = 0; k < 3; k++) begin
            rd(0, A_RX, v, rr); chk("R2 order and data side1 to side0", v, ~pat(k));
        end

        // R10: push and pop of the same queue in one cycle
        wr(1, A_TX, 32'h0000_00A1);
        fork
            wr(1, A_TX, 32'h0000_00A2);
            rd(0, A_RX, v, rr);
        join
        chk("R10 pop during push returns older word", v, 32'hA1);
        rd(0, A_RX, v, rr); chk("R10 pushed word kept", v, 32'hA2);
        rd(0, A_ST, v, rr); chk("R10 queue empty afterwards", 32'(v[0]), 1);

        // R7: error-word read racing a new full error
        for (int k = 0; k < DEPTH; k++) wr(0, A_TX, pat(k + 40));
        rd(0, A_ER, v, rr); chk("R7 error clean before race", v, 0);
        fork
            wr(0, A_TX, 32'h5555_5555);
            rd(0, A_ER, v, rr);
        join
        chk("R7 racing read returns prior value", v, 0);
        rd(0, A_ER, v, rr); chk("R7 same-cycle error survives clear", v, 32'h2);
        rd(0, A_ER, v, rr); chk("R7 cleared on next read", v, 0);
        wr(0, A_STH, 5);

        // R9: mid-run reset empties queues and clears registers
        do_reset();
        rd(0, A_ST, v, rr);  chk("R9 status0 after mid reset", v, 32'h5);
        rd(1, A_ST, v, rr);  chk("R9 status1 after mid reset", v, 32'h5);
        rd(0, A_STH, v, rr); chk("R9 threshold cleared", v, 0);
        rd(1, A_RX, v, rr);  chk("R9 queue emptied", v, 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule